// File: doc/BRIEF.md
# Banked Register Redirection Table

The block keeps a small table of sixteen 16-bit redirection entries and turns a selected slice of it into two lookup tables, one for integer registers and one for floating-point registers, each indexed by a 5-bit register key. Software fills the table through eight configuration registers. Each write lands on a group of two consecutive entries, or four in 64-bit mode, and every entry above that group is wiped on the same write. The table can therefore be reloaded from the bottom up, and whatever stays nonzero is exactly what was written last.

A bank number and a span code pick a window of entries. The window is cut to a limit that depends on the privilege level. When the window or the table changes, the block clears both lookup tables and walks the window from its lowest entry upward, one entry per clock. It fills one lookup slot per entry and stops early at the first all-zero entry. A busy flag is high during the walk, and lookups made during the walk read as inactive. Decode logic uses the lookups to find out whether a register key is redirected, to which register, at what element width and whether it acts as a vector.

Top module: `regcfg_table`

## Requirements
- R1: With `wide_mode` low, a write to configuration register n (`cfg_sel`) stores `cfg_wdata[15:0]` in entry 2n and `cfg_wdata[31:16]` in entry 2n+1; bits 63:32 have no effect.
- R2: With `wide_mode` high, the write also stores `cfg_wdata[47:32]` in entry 2n+2 and `cfg_wdata[63:48]` in entry 2n+3; any slice that would fall beyond entry 15 is dropped.
- R3: The same write sets every entry above the written group, up to entry 15, to zero. Entries below the group keep their values.
- R4: The window starts at min(bank*4, L) and ends, exclusive, at min(bank*4 + 2^(span+1), L). L is 16 for `priv`=3, 8 for `priv`=1 and 4 for any other `priv` code. Bank, span and privilege are sampled in the cycle that starts the walk.
- R5: The walk visits window entries in increasing order and stops at the first entry that is all zero. It does not visit entries beyond that one.
- R6: Entry layout: key in bits 4:0, type in bit 5 (1 selects the integer table, 0 the floating-point table), vector flag in bit 6, element width in bits 8:7, target register in bits 13:9. Bits 15:14 are ignored. A visited entry makes the slot at its key active and records its vector flag, element width and target.
- R7: A walk starts on the clock edge after any configuration write, and after any cycle in which `bank` or `span_sel` differs from its value in the previous cycle. Both lookup tables are cleared when the walk starts. A change of `priv` alone starts no walk and leaves the lookups unchanged.
- R8: `busy` goes high one cycle after the walk starts. It stays high for k+1 cycles, where k is the number of entries the walk visits. While `busy` is high, every lookup reads inactive with all fields zero.
- R9: After reset all entries are zero, every lookup is inactive and `busy` is low.
- R10: When two visited entries carry the same key and type, the slot holds the fields of the higher-numbered entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register number n |
| cfg_wdata | input | 64 | Packed entries to write |
| wide_mode | input | 1 | 1 = 64-bit writes (four entries), 0 = 32-bit writes (two entries) |
| bank | input | 2 | Window bank (start = bank*4) |
| span_sel | input | 2 | Window span code (length 2^(span_sel+1)) |
| priv | input | 2 | Privilege level: 3 machine, 1 supervisor, others user |
| int_key | input | 5 | Integer-table lookup key |
| fp_key | input | 5 | Floating-point-table lookup key |
| busy | output | 1 | Walk in progress |
| int_act | output | 1 | Integer slot active |
| int_vec | output | 1 | Integer slot vector flag |
| int_elw | output | 2 | Integer slot element width |
| int_ridx | output | 5 | Integer slot target register |
| fp_act | output | 1 | Floating-point slot active |
| fp_vec | output | 1 | Floating-point slot vector flag |
| fp_elw | output | 2 | Floating-point slot element width |
| fp_ridx | output | 5 | Floating-point slot target register |

## Verification
A write or a window change is sampled at edge E0. The table update lands at E0, `busy` is high from E0 to E(k+1), and the lookup results are final after E(k+1). The lookups are combinational reads of the slots, so they follow a key change in the same cycle. The bench applies each stimulus half a cycle before E0 and samples `busy` at every falling edge after E0. It checks that `busy` stays high for exactly k+1 samples, with k taken from its own model walk, and that a lookup reads inactive in the first busy sample. Only after `busy` has fallen does it sweep all 32 keys of both tables, reading each result one nanosecond after setting the key. A stimulus that should start no walk is checked for `busy` low at the first falling edge after E0.

// File: rtl/regcfg_pkg.sv
`timescale 1ns/1ps
package regcfg_pkg;
    parameter int NUM_ENT   = 16;
    parameter int ENT_W     = 16;
    parameter int NUM_REG   = 8;
    parameter int DATA_W    = 64;
    parameter int KEY_W     = 5;
    parameter int ELW_W     = 2;
    parameter int RIDX_W    = 5;
    parameter int BANK_W    = 2;
    parameter int SPAN_W    = 2;
    parameter int BANK_STEP = 4;
    parameter int LIM_M     = 16;
    parameter int LIM_S     = 8;
    parameter int LIM_U     = 4;

    localparam int NUM_SLOT    = 1 << KEY_W;
    localparam int SEL_W       = $clog2(NUM_REG);
    localparam int PTR_W       = $clog2(NUM_ENT) + 1;
    localparam int IDX_W       = $clog2(NUM_ENT);
    localparam int WIDE_SPAN   = DATA_W / ENT_W;
    localparam int NARROW_SPAN = WIDE_SPAN / 2;
    localparam int GRP_STEP    = NUM_ENT / NUM_REG;

    typedef logic [ENT_W-1:0] entry_t;

    typedef struct packed {
        logic [1:0]        rsvd;
        logic [RIDX_W-1:0] ridx;
        logic [ELW_W-1:0]  elw;
        logic              vec;
        logic              is_int;
        logic [KEY_W-1:0]  key;
    } ent_fields_t;

    typedef struct packed {
        logic              act;
        logic              vec;
        logic [ELW_W-1:0]  elw;
        logic [RIDX_W-1:0] ridx;
    } slot_t;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_MACH  = 2'd3
    } lvl_e;

    function automatic int lvl_limit(logic [1:0] lvl);
        case (lvl)
            LVL_MACH:  return LIM_M;
            LVL_SUPER: return LIM_S;
            default:   return LIM_U;
        endcase
    endfunction

    function automatic logic [PTR_W-1:0] win_lo(logic [BANK_W-1:0] b, logic [1:0] lvl);
        int s;
        s = int'(b) * BANK_STEP;
        if (s > lvl_limit(lvl)) s = lvl_limit(lvl);
        return PTR_W'(s);
    endfunction

    function automatic logic [PTR_W-1:0] win_hi(logic [BANK_W-1:0] b,
                                                logic [SPAN_W-1:0] sp, logic [1:0] lvl);
        int e;
        e = int'(b) * BANK_STEP + (2 << sp);
        if (e > lvl_limit(lvl)) e = lvl_limit(lvl);
        return PTR_W'(e);
    endfunction
endpackage

// File: rtl/regcfg_store.sv
`timescale 1ns/1ps
module regcfg_store
    import regcfg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         wide,
    output logic [NUM_ENT-1:0][ENT_W-1:0] tbl_o
);
    logic [NUM_ENT-1:0][ENT_W-1:0] tbl_q, tbl_d;
    int base, span;

    assign base = int'(sel) * GRP_STEP;
    assign span = wide ? WIDE_SPAN : NARROW_SPAN;

    always_comb begin
        tbl_d = tbl_q;
        if (we) begin
            for (int i = 0; i < NUM_ENT; i++) begin
                if (i >= base && i < base + span)
                    tbl_d[i] = wdata[(i - base) * ENT_W +: ENT_W];
                else if (i >= base + span)
                    tbl_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    assign tbl_o = tbl_q;
endmodule

// File: rtl/regcfg_unpack.sv
`timescale 1ns/1ps
module regcfg_unpack
    import regcfg_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          restart,
    input  logic [PTR_W-1:0]              lo,
    input  logic [PTR_W-1:0]              hi,
    input  logic [NUM_ENT-1:0][ENT_W-1:0] tbl,
    input  logic [KEY_W-1:0]              int_key,
    input  logic [KEY_W-1:0]              fp_key,
    output logic                          busy,
    output slot_t                         int_slot,
    output slot_t                         fp_slot
);
    logic             busy_q;
    logic [PTR_W-1:0] ptr_q, hi_q;
    slot_t            int_tab [NUM_SLOT];
    slot_t            fp_tab  [NUM_SLOT];
    ent_fields_t      cur;
    slot_t            fill;
    logic             adv;

    assign cur  = ent_fields_t'(tbl[ptr_q[IDX_W-1:0]]);
    assign adv  = busy_q && (ptr_q < hi_q) && (tbl[ptr_q[IDX_W-1:0]] != '0);
    assign fill = '{act: 1'b1, vec: cur.vec, elw: cur.elw, ridx: cur.ridx};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            busy_q <= !rst;
            ptr_q  <= rst ? '0 : lo;
            hi_q   <= rst ? '0 : hi;
            for (int k = 0; k < NUM_SLOT; k++) begin
                int_tab[k] <= '0;
                fp_tab[k]  <= '0;
            end
        end else if (busy_q) begin
            if (adv) begin
                if (cur.is_int) int_tab[cur.key] <= fill;
                else            fp_tab[cur.key]  <= fill;
                ptr_q <= ptr_q + 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy     = busy_q;
    assign int_slot = busy_q ? '0 : int_tab[int_key];
    assign fp_slot  = busy_q ? '0 : fp_tab[fp_key];
endmodule

// File: rtl/regcfg_table.sv
`timescale 1ns/1ps
module regcfg_table
    import regcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic                  wide_mode,
    input  logic [BANK_W-1:0]     bank,
    input  logic [SPAN_W-1:0]     span_sel,
    input  logic [1:0]            priv,
    input  logic [KEY_W-1:0]      int_key,
    input  logic [KEY_W-1:0]      fp_key,
    output logic                  busy,
    output logic                  int_act,
    output logic                  int_vec,
    output logic [ELW_W-1:0]      int_elw,
    output logic [RIDX_W-1:0]     int_ridx,
    output logic                  fp_act,
    output logic                  fp_vec,
    output logic [ELW_W-1:0]      fp_elw,
    output logic [RIDX_W-1:0]     fp_ridx
);
    logic [NUM_ENT-1:0][ENT_W-1:0] tbl_w;
    logic [BANK_W-1:0] bank_q;
    logic [SPAN_W-1:0] span_q;
    logic              restart;
    slot_t             int_s, fp_s;

    always_ff @(posedge clk) begin
        bank_q <= bank;
        span_q <= span_sel;
    end

    assign restart = cfg_we || (bank != bank_q) || (span_sel != span_q);

    regcfg_store u_store (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .wide(wide_mode), .tbl_o(tbl_w)
    );

    regcfg_unpack u_unpack (
        .clk(clk), .rst(rst), .restart(restart),
        .lo(win_lo(bank, priv)), .hi(win_hi(bank, span_sel, priv)),
        .tbl(tbl_w), .int_key(int_key), .fp_key(fp_key),
        .busy(busy), .int_slot(int_s), .fp_slot(fp_s)
    );

    assign int_act  = int_s.act;
    assign int_vec  = int_s.vec;
    assign int_elw  = int_s.elw;
    assign int_ridx = int_s.ridx;
    assign fp_act   = fp_s.act;
    assign fp_vec   = fp_s.vec;
    assign fp_elw   = fp_s.elw;
    assign fp_ridx  = fp_s.ridx;
endmodule

// File: rtl/regcfg_table_chk.sv
`timescale 1ns/1ps
module regcfg_table_chk
    import regcfg_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          cfg_we,
    input logic [SEL_W-1:0]              cfg_sel,
    input logic                          wide_mode,
    input logic [BANK_W-1:0]             bank,
    input logic [SPAN_W-1:0]             span_sel,
    input logic                          restart,
    input logic                          busy,
    input logic                          int_act,
    input logic                          fp_act,
    input logic [NUM_ENT-1:0][ENT_W-1:0] tbl
);
    logic [PTR_W:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)          run_cnt <= '0;
        else if (restart) run_cnt <= '0;
        else if (busy)    run_cnt <= run_cnt + 1'b1;
        else              run_cnt <= '0;
    end

    // R8: lookups read inactive during the walk
    a_r8_idle_lookup: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!int_act && !fp_act));

    // R7: a configuration write starts a walk
    a_r7_write_walk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> busy);

    // R7: a window change starts a walk
    a_r7_window_walk: assert property (@(posedge clk) disable iff (rst)
        ((bank != $past(bank)) || (span_sel != $past(span_sel))) |=> busy);

    // R3: a write below the top group wipes the last entry
    a_r3_tail_cleared: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (int'(cfg_sel) * GRP_STEP +
                    (wide_mode ? WIDE_SPAN : NARROW_SPAN) < NUM_ENT))
        |=> (tbl[NUM_ENT-1] == '0));

    // R8: a walk ends within one cycle more than the table depth
    a_r8_walk_bounded: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= (PTR_W+1)'(NUM_ENT + 1));
endmodule

bind regcfg_table regcfg_table_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .wide_mode(wide_mode), .bank(bank), .span_sel(span_sel),
    .restart(restart), .busy(busy), .int_act(int_act), .fp_act(fp_act),
    .tbl(tbl_w)
);

// File: tb/tb_regcfg_table.sv
`timescale 1ns/1ps
module tb_regcfg_table;
    logic        clk = 0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic        wide_mode;
    logic [1:0]  bank, span_sel, priv;
    logic [4:0]  int_key, fp_key;
    logic        busy, int_act, int_vec, fp_act, fp_vec;
    logic [1:0]  int_elw, fp_elw;
    logic [4:0]  int_ridx, fp_ridx;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [15:0] m_tbl [16];
    logic [8:0]  m_int [32];
    logic [8:0]  m_fp  [32];
    logic [1:0]  cur_bank, cur_span;

    always #2 clk = ~clk;

    regcfg_table dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .wide_mode(wide_mode), .bank(bank),
        .span_sel(span_sel), .priv(priv), .int_key(int_key), .fp_key(fp_key),
        .busy(busy), .int_act(int_act), .int_vec(int_vec), .int_elw(int_elw),
        .int_ridx(int_ridx), .fp_act(fp_act), .fp_vec(fp_vec),
        .fp_elw(fp_elw), .fp_ridx(fp_ridx)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] mk(bit is_int, int key, bit vec, int elw, int ridx);
        return {2'b00, 5'(ridx), 2'(elw), vec, is_int, 5'(key)};
    endfunction

    function automatic void m_write(int sel, logic [63:0] d, bit wide);
        int base = sel * 2;
        int span = wide ? 4 : 2;
        for (int i = 0; i < 16; i++) begin
            if (i >= base && i < base + span) m_tbl[i] = d[(i - base) * 16 +: 16];
            else if (i >= base + span)        m_tbl[i] = 16'h0;
        end
    endfunction

    function automatic int m_walk(int b, int sp, int lv);
        int lim = (lv == 3) ? 16 : (lv == 1) ? 8 : 4;
        int lo = (b * 4 > lim) ? lim : b * 4;
        int hi = (b * 4 + (2 << sp) > lim) ? lim : b * 4 + (2 << sp);
        int k = 0;
        for (int i = 0; i < 32; i++) begin m_int[i] = 0; m_fp[i] = 0; end
        for (int p = lo; p < hi; p++) begin
            logic [15:0] e = m_tbl[p];
            if (e == 16'h0) break;
            if (e[5]) m_int[e[4:0]] = {1'b1, e[6], e[8:7], e[13:9]};
            else      m_fp[e[4:0]]  = {1'b1, e[6], e[8:7], e[13:9]};
            k++;
        end
        return k;
    endfunction

    task automatic sweep(input string tag);
        for (int key = 0; key < 32; key++) begin
            int_key = 5'(key);
            fp_key  = 5'(key);
            #1;
            check($sformatf("%s int key %0d", tag, key),
                  {23'd0, int_act, int_vec, int_elw, int_ridx}, {23'd0, m_int[key]});
            check($sformatf("%s fp key %0d", tag, key),
                  {23'd0, fp_act, fp_vec, fp_elw, fp_ridx}, {23'd0, m_fp[key]});
        end
    endtask

    task automatic step(input string tag, input bit we, input int sel, input logic [63:0] d,
                        input bit wide, input int b, input int sp, input int lv);
        bit trig;
        int k = 0;
        int cnt = 0;
        @(negedge clk);
        cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = d; wide_mode = wide;
        bank = 2'(b); span_sel = 2'(sp); priv = 2'(lv);
        trig = we || (2'(b) != cur_bank) || (2'(sp) != cur_span);
        cur_bank = 2'(b); cur_span = 2'(sp);
        if (we) m_write(sel, d, wide);
        if (trig) k = m_walk(b, sp, lv);
        @(negedge clk);
        cfg_we = 0;
        if (trig) begin
            int_key = 5'd0; fp_key = 5'd0;
            check({tag, " R8 lookup idle while busy"}, {30'd0, int_act, fp_act}, 32'd0);
            while (busy && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            check({tag, " R8 busy length"}, cnt, k + 1);
        end else begin
            check({tag, " R7 no walk"}, {31'd0, busy}, 32'd0);
        end
        sweep(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; wide_mode = 0;
        bank = 0; span_sel = 0; priv = 3; int_key = 0; fp_key = 0;
        cur_bank = 0; cur_span = 0;
        for (int i = 0; i < 16; i++) m_tbl[i] = 0;
        void'(m_walk(0, 0, 3));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R9 busy after reset", {31'd0, busy}, 32'd0);
        sweep("R9 reset");

        // R1 narrow packing; high half ignored
        step("R1 R6 narrow", 1, 0,
             {mk(1, 3, 1, 2, 9), mk(0, 7, 1, 1, 4), mk(0, 4, 0, 3, 17), mk(1, 12, 1, 1, 30)},
             0, 0, 3, 3);
        // R2 wide packing into entries 2..5
        step("R2 R5 wide", 1, 1,
             {mk(1, 20, 0, 1, 2), mk(0, 21, 1, 0, 3), mk(1, 22, 1, 3, 5), mk(0, 23, 0, 2, 6)},
             1, 0, 2, 3);
        // R3 write to reg 0 wipes entries 2..15
        step("R3 clear above", 1, 0, {32'hFFFF_FFFF, mk(1, 1, 0, 0, 1), mk(0, 2, 0, 0, 2)},
             0, 0, 3, 3);
        // R5 zero entry in the middle stops the walk
        step("R5 zero stop", 1, 0,
             {mk(1, 9, 0, 0, 9), mk(1, 8, 0, 0, 8), 16'h0, mk(1, 5, 1, 1, 5)}, 1, 0, 3, 3);
        // R10 later entry with same key wins
        step("R10 dup key", 1, 0,
             {mk(1, 6, 0, 2, 11), mk(1, 6, 1, 1, 22), mk(0, 6, 1, 3, 7), mk(1, 6, 0, 1, 3)},
             1, 0, 1, 3);
        // R2 top register in wide mode drops the slices past entry 15
        step("R2 top drop", 1, 7,
             {mk(1, 1, 1, 1, 1), mk(1, 2, 1, 1, 2), mk(0, 14, 0, 1, 14), mk(1, 15, 1, 2, 15)},
             1, 3, 0, 3);
        // R4 window clipped by supervisor limit, bank 1 span 3 -> entries 4..7
        step("R4 fill", 1, 2,
             {mk(1, 10, 0, 0, 10), mk(0, 11, 1, 1, 11), mk(1, 12, 1, 2, 12), mk(0, 13, 0, 3, 13)},
             1, 3, 0, 3);
        step("R4 super clip", 0, 0, 64'h0, 0, 1, 3, 1);
        step("R4 user empty", 0, 0, 64'h0, 0, 1, 2, 0);
        // R7 privilege change alone starts no walk
        step("R7 priv only", 0, 0, 64'h0, 0, 1, 2, 3);
        step("R7 span change", 0, 0, 64'h0, 0, 1, 0, 3);

        for (int n = 0; n < 40; n++) begin
            int lv = $urandom_range(0, 2);
            step($sformatf("R1 R2 R3 R4 R5 R6 R10 rand%0d", n),
                 ($urandom_range(0, 3) != 0), $urandom_range(0, 7),
                 {$urandom, $urandom}, $urandom_range(0, 1),
                 $urandom_range(0, 3), $urandom_range(0, 3), (lv == 2) ? 3 : lv);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule